// File: doc/BRIEF.md
# Pseudocarry Lookahead Adder

This block adds two unsigned operands of a configurable width and a carry-in. It returns the sum and the carry-out. Inside, it does not compute true carries. It computes pseudocarries instead: a bit generate is the AND of the operand bits and a bit propagate is their inclusive OR. Each pseudocarry term therefore needs one literal fewer than the matching carry term, and the true carry is recovered as the propagate of a bit ANDed with its pseudocarry. The carry-in enters the tree as an extra lowest position whose generate is the carry-in and whose propagate is forced to one. A parallel-prefix tree of logarithmic depth merges (pseudocarry, group-propagate) pairs. On its first level it uses the reduced form, in which two adjacent single positions merge into a plain OR of their generates.

Each sum bit is the half-sum of its operand bits (XOR) XORed with the true carry of the position just below it. The carry-out is the true carry at the top position.

The arithmetic core is purely combinational. It sits behind a one-deep output stage with valid/ready handshakes on both sides. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle and held steady until the consumer raises `out_ready`. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. Full throughput is one beat per cycle while `out_ready` stays high.

Top module: `ling_adder`

## Requirements
- R1: For every accepted beat, `out_sum` equals the low WIDTH bits of in_a + in_b + in_carry (unsigned arithmetic).
- R2: For every accepted beat, `out_carry` equals bit WIDTH of the same (WIDTH+1)-bit total.
- R3: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1, so a stalled full output stage refuses new input.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sum` and `out_carry` hold their values on the next cycle.
- R5: A beat taken at a clock edge makes `out_valid` 1 after that same edge.
- R6: While `rst_n` is 0 (active-low, asynchronous), `out_valid` is 0 and `in_ready` is 1.
- R7: A carry that travels through every bit is handled correctly: all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1, and all-ones plus all-ones with carry-in 1 gives sum all-ones and carry-out 1.
- R8: An edge where `in_ready` is 1 and `in_valid` is 0 leaves `out_valid` at 0 after that edge.
- R9: Results leave in the order their beats were taken, one result per beat, with no loss or duplication under any `out_ready` pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_carry | input | 1 | Carry-in |
| out_valid | output | 1 | Result beat presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | WIDTH | Sum bits |
| out_carry | output | 1 | Carry-out |

## Verification
The properties assume that upstream drives `in_valid`, operands and carry-in, and downstream drives `out_ready`, as settled values at each rising edge. No input may be X, since the reference total is formed from the sampled operands. The stimulus meets this by changing every input a fixed delay after the rising edge and reading outputs on the falling edge. The stall pattern on `out_ready` is free-running and random. Operands are held until the beat is taken, so a refused beat is never counted as a result.

// File: rtl/ling_pkg.sv
package ling_pkg;

  // One node of the prefix tree: group pseudocarry and group propagate.
  typedef struct packed {
    logic h;
    logic i;
  } ling_node_t;

  // General merge of an upper span with the span right below it.
  function automatic ling_node_t ling_merge(input ling_node_t up, input ling_node_t lo);
    ling_node_t r;
    r.h = up.h | (up.i & lo.h);
    r.i = up.i & lo.i;
    return r;
  endfunction

  // First-level merge of two single positions: the lower generate implies
  // the upper group propagate, so the propagate literal drops out.
  function automatic ling_node_t ling_merge_pair(input ling_node_t up, input ling_node_t lo);
    ling_node_t r;
    r.h = up.h | lo.h;
    r.i = up.i & lo.i;
    return r;
  endfunction

endpackage

// File: rtl/ling_bit_prep.sv
module ling_bit_prep #(
  parameter int WIDTH = 32,
  localparam int POS = WIDTH + 1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [POS-1:0]   gen,
  output logic [POS-1:0]   prp,
  output logic [WIDTH-1:0] half
);
  // Position 0 stands for the carry-in; position k>0 is operand bit k-1.
  assign gen[0] = cin;
  assign prp[0] = 1'b1;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign gen[k+1] = a[k] & b[k];
    assign prp[k+1] = a[k] | b[k];
    assign half[k]  = a[k] ^ b[k];
  end
endmodule

// File: rtl/ling_prefix_tree.sv
module ling_prefix_tree
  import ling_pkg::*;
#(
  parameter int POS = 33,
  localparam int LVLS = (POS > 1) ? $clog2(POS) : 1
) (
  input  logic [POS-1:0] gen,
  input  logic [POS-1:0] prp,
  output logic [POS-1:0] pc
);
  ling_node_t node [0:LVLS][POS];

  // Leaves: pseudocarry seed is the generate, group propagate is the
  // propagate of the position below (none below position 0).
  for (genvar k = 0; k < POS; k++) begin : g_leaf
    assign node[0][k].h = gen[k];
    if (k == 0) begin : g_base
      assign node[0][k].i = 1'b0;
    end else begin : g_up
      assign node[0][k].i = prp[k-1];
    end
  end

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    for (genvar k = 0; k < POS; k++) begin : g_pos
      if (k < DIST) begin : g_pass
        assign node[l+1][k] = node[l][k];
      end else if (l == 0) begin : g_pair
        assign node[l+1][k] = ling_merge_pair(node[l][k], node[l][k-DIST]);
      end else begin : g_merge
        assign node[l+1][k] = ling_merge(node[l][k], node[l][k-DIST]);
      end
    end
  end

  for (genvar k = 0; k < POS; k++) begin : g_out
    assign pc[k] = node[LVLS][k].h;
  end
endmodule

// File: rtl/ling_sum.sv
module ling_sum #(
  parameter int WIDTH = 32,
  localparam int POS = WIDTH + 1
) (
  input  logic [WIDTH-1:0] half,
  input  logic [POS-1:0]   prp,
  input  logic [POS-1:0]   pc,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  // Bit k sits at position k+1; its incoming true carry is prp&pc at position k.
  for (genvar k = 0; k < WIDTH; k++) begin : g_sum
    assign sum[k] = half[k] ^ (prp[k] & pc[k]);
  end
  assign cout = prp[WIDTH] & pc[WIDTH];
endmodule

// File: rtl/ling_adder.sv
module ling_adder #(
  parameter int WIDTH = 32,
  localparam int POS = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry
);
  logic [POS-1:0]   gen;
  logic [POS-1:0]   prp;
  logic [POS-1:0]   pc;
  logic [WIDTH-1:0] half;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  ling_bit_prep #(.WIDTH(WIDTH)) u_prep (
    .a(in_a), .b(in_b), .cin(in_carry),
    .gen(gen), .prp(prp), .half(half)
  );

  ling_prefix_tree #(.POS(POS)) u_tree (
    .gen(gen), .prp(prp), .pc(pc)
  );

  ling_sum #(.WIDTH(WIDTH)) u_sum (
    .half(half), .prp(prp), .pc(pc),
    .sum(sum_c), .cout(cout_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_carry <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum   <= sum_c;
        out_carry <= cout_c;
      end
    end
  end
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             in_carry,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_sum,
  input logic             out_carry
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, in_carry};

  // R1 and R2: result of a taken beat equals the arithmetic total
  assert_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ({out_carry, out_sum} == $past(ref_total)));

  // R3: stalled full stage refuses input
  assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4: stalled result holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry)));

  // R5: taken beat appears next cycle
  assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8: empty edge empties the stage
  assert_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_carry(in_carry), .out_valid(out_valid),
  .out_ready(out_ready), .out_sum(out_sum), .out_carry(out_carry)
);

// File: tb/test_ling_adder.sv
module ling_lane #(
  parameter int W = 8,
  parameter bit EXH = 1'b0,
  parameter int NRAND = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   checks,
  output int   bad
);
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_carry = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_sum;
  logic         out_carry;
  logic         stall = 1'b0;
  logic         took_d = 1'b0;
  logic         idle_d = 1'b0;
  logic         held_v = 1'b0;
  logic [W:0]   held_val = '0;
  logic [W:0]   expq[$];

  ling_adder #(.WIDTH(W)) i_ling_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_carry(in_carry), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_carry(out_carry)
  );

  initial begin
    done = 1'b0; checks = 0; bad = 0;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s W=%0d actual=%0h expected=%0h", req, W, act, exp);
    end
  endtask

  // Consumer: free-running random stall pattern while enabled
  initial forever begin
    @(posedge clk); #2;
    out_ready = stall ? ($urandom_range(3) != 0) : 1'b1;
  end

  // Record what happened at each edge (inputs settle 2 units after the edge)
  always @(posedge clk) begin
    took_d <= rst_n && in_valid && in_ready;
    idle_d <= rst_n && !in_valid && in_ready;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      // R3: readiness rule
      check(in_ready == (!out_valid || out_ready), "R3", 64'(in_ready), 64'(!out_valid || out_ready));
      if (took_d) check(out_valid == 1'b1, "R5", 64'(out_valid), 64'd1);
      if (idle_d) check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
      if (held_v) check(out_valid && ({out_carry, out_sum} == held_val), "R4",
                        64'({out_carry, out_sum}), 64'(held_val));
      held_v   <= out_valid && !out_ready;
      held_val <= {out_carry, out_sum};
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", 64'd1, 64'd0);
        end else begin
          logic [W:0] e;
          e = expq.pop_front();
          check(out_sum == e[W-1:0], "R1", 64'(out_sum), 64'(e[W-1:0]));
          check(out_carry == e[W], "R2", 64'(out_carry), 64'(e[W]));
        end
      end
    end
  end

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(posedge clk); #2;
    in_valid = 1'b1; in_a = a; in_b = b; in_carry = c;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        expq.push_back({1'b0, a} + {1'b0, b} + {{W{1'b0}}, c});
        break;
      end
    end
  endtask

  task automatic go_idle();
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  initial begin
    logic [W-1:0] ones;
    logic [W-1:0] alt;
    ones = '1;
    for (int k = 0; k < W; k++) alt[k] = k[0];
    // R6: state while reset is held
    @(negedge clk);
    check(out_valid == 1'b0, "R6", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R6", 64'(in_ready), 64'd1);
    wait (rst_n);
    // R7: full-length carry chains and other corners
    send(ones, '0, 1'b1);
    send(ones, ones, 1'b1);
    send('0, '0, 1'b0);
    send(ones, '0, 1'b0);
    send(alt, ~alt, 1'b1);
    send({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);
    send({{(W-1){1'b0}}, 1'b1}, ones, 1'b0);
    go_idle();
    repeat (3) @(posedge clk);
    if (EXH) begin
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < (1 << W); a++)
          for (int b = 0; b < (1 << W); b++)
            send(W'(a), W'(b), c[0]);
      go_idle();
    end
    // R9: ordering under random back-pressure
    stall = 1'b1;
    for (int n = 0; n < NRAND; n++) begin
      logic [63:0] ra;
      logic [63:0] rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (n % 7 == 0) rb = ~ra;
      send(ra[W-1:0], rb[W-1:0], 1'($urandom_range(1)));
      if (n % 11 == 0) go_idle();
    end
    go_idle();
    stall = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
    check(expq.size() == 0, "R9", 64'(expq.size()), 64'd0);
    done = 1'b1;
  end
endmodule

module test_ling_adder;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d8, d32, d64;
  int   c8, c32, c64, b8, b32, b64;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ling_lane #(.W(8),  .EXH(1'b1), .NRAND(500))  u_w8  (.clk(clk), .rst_n(rst_n), .done(d8),  .checks(c8),  .bad(b8));
  ling_lane #(.W(32), .EXH(1'b0), .NRAND(3000)) u_w32 (.clk(clk), .rst_n(rst_n), .done(d32), .checks(c32), .bad(b32));
  ling_lane #(.W(64), .EXH(1'b0), .NRAND(3000)) u_w64 (.clk(clk), .rst_n(rst_n), .done(d64), .checks(c64), .bad(b64));

  initial begin
    int cyc;
    int extra;
    extra = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc = 0;
    while (!(d8 && d32 && d64) && cyc < LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d8 && d32 && d64)) begin
      extra = 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, LIMIT);
    end
    $display("  test done: total=%0d bad=%0d", c8 + c32 + c64 + extra, b8 + b32 + b64 + extra);
    $finish;
  end
endmodule